// File: doc/BRIEF.md
# Set-Associative Cache with World Tag

This block is a small read-allocate, write-through cache that sits between one requester and a word-wide memory port. Every request carries a world bit (0 = secure, 1 = non-secure) next to its address. Each stored line records the world that filled it, and a lookup only hits when that recorded bit equals the bit of the request. Lines of both worlds therefore share the arrays at the same time, and a world switch needs no flush.

The address is split into a set index (low bits) and a tag (the remaining bits). A read miss fetches one word from memory over a single-pulse read request followed by a response strobe. The word is then installed in a free way of the set if one exists. Otherwise it goes into a way picked by an LFSR, with no regard to the world of the line it replaces. Writes always go through to memory and update the cached copy only when they hit. Because a hit answers in one cycle and a miss takes the whole memory round trip, the latency difference shows at the ports.

Top module: `sec_tag_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `mem_rd` and `mem_wr` are 0. After reset or a one-cycle `inv_all` pulse, every line filled earlier misses.
- R2: A read hit raises `rsp_valid` with `rsp_hit` = 1 and the cached word on the clock edge that accepts the request, and it issues no memory read.
- R3: A read miss raises `mem_rd` for exactly one cycle, starting on the accepting edge, with `mem_addr` and `mem_ns` equal to the request. `req_ready` stays 0 until the answer arrives. On the edge that samples `mem_rvalid`, `rsp_valid` rises with `rsp_hit` = 0 and `rsp_rdata` equal to `mem_rdata`.
- R4: A hit needs a valid line, an equal tag and an equal world bit. The same address requested from the other world misses and fetches with that world's bit.
- R5: After both worlds have read the same address, both copies hit without any flush in between.
- R6: A fill uses a free way of its set when one exists, so WAYS distinct tags read into one empty set all hit afterwards.
- R7: A fill into a full set replaces a resident line whatever that line's world bit is. The new line hits on the next request, and at least one of the earlier lines then misses. This holds for secure fills over non-secure lines and for the reverse.
- R8: A write raises `mem_wr` for one cycle on the accepting edge, with the request's address, world bit and data. `rsp_valid` rises on the same edge, and `rsp_hit` shows whether the write matched a line.
- R9: A write hit updates the cached word. A write miss allocates nothing, so a following read of that address misses and returns the written word from memory.
- R10: The set index is address bits [log2(SETS)-1:0]. Lines in different sets never evict each other, so one line in each of the SETS sets all stay resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all | input | 1 | Clears every valid bit; blocks new requests while high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ns | input | 1 | World bit of the request (1 = non-secure) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Request matched a cached line |
| rsp_rdata | output | DATA_W | Read data |
| mem_rd | output | 1 | One-cycle memory read request |
| mem_wr | output | 1 | One-cycle memory write |
| mem_addr | output | ADDR_W | Memory address |
| mem_ns | output | 1 | World bit passed to memory |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
A corrupted world bit or tag in a line shows up on the next request to that address. The request either gets a one-cycle `rsp_hit` where a fetch was due, or it triggers an extra `mem_rd` pulse and a long response where a hit was due. A wrong victim choice, such as overwriting a still-free way, appears only when the displaced address is read again, which can be many requests later. For that reason the bench fills whole sets before it re-reads them. A stale data word appears as a wrong `rsp_rdata` on the first hit after a write.

// File: rtl/sec_tag_cache.sv
module sec_tag_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  parameter int WAYS   = 4,
  parameter logic [7:0] LFSR_SEED = 8'hB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_ns,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ns,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0]   vld_q [SETS];
  logic [WAYS-1:0]   nsb_q [SETS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [DATA_W-1:0] dat_q [SETS][WAYS];

  logic              waiting_q;
  logic [7:0]        lfsr_q;
  logic [IDX_W-1:0]  f_idx_q;
  logic [TAG_W-1:0]  f_tag_q;
  logic              f_ns_q;
  logic [WAY_W-1:0]  f_way_q;

  wire [IDX_W-1:0] idx    = req_addr[IDX_W-1:0];
  wire [TAG_W-1:0] tag    = req_addr[ADDR_W-1:IDX_W];
  wire             accept = req_valid && req_ready;
  wire             fill   = waiting_q && mem_rvalid;

  assign req_ready = !waiting_q && !inv_all;

  logic [WAYS-1:0]   hit_vec;
  logic [DATA_W-1:0] hit_data;
  logic [WAY_W-1:0]  victim;
  logic              any_free;

  always_comb begin
    hit_data = '0;
    victim   = lfsr_q[WAY_W-1:0];
    any_free = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld_q[idx][w] && (tag_q[idx][w] == tag) && (nsb_q[idx][w] == req_ns);
      if (hit_vec[w]) hit_data = dat_q[idx][w];
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[idx][w]) begin
        victim   = WAY_W'(w);
        any_free = 1'b1;
      end
    end
  end

  wire hit = |hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting_q <= 1'b0;
      lfsr_q    <= LFSR_SEED;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_rdata <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_ns    <= 1'b0;
      mem_wdata <= '0;
      f_idx_q   <= '0;
      f_tag_q   <= '0;
      f_ns_q    <= 1'b0;
      f_way_q   <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        nsb_q[s] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      if (accept) begin
        mem_addr <= req_addr;
        mem_ns   <= req_ns;
        if (req_write) begin
          mem_wr    <= 1'b1;
          mem_wdata <= req_wdata;
          rsp_valid <= 1'b1;
          rsp_hit   <= hit;
        end else if (hit) begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b1;
          rsp_rdata <= hit_data;
        end else begin
          mem_rd    <= 1'b1;
          waiting_q <= 1'b1;
          f_idx_q   <= idx;
          f_tag_q   <= tag;
          f_ns_q    <= req_ns;
          f_way_q   <= victim;
        end
      end
      if (fill) begin
        waiting_q <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b0;
        rsp_rdata <= mem_rdata;
        lfsr_q    <= {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
        vld_q[f_idx_q][f_way_q] <= 1'b1;
        nsb_q[f_idx_q][f_way_q] <= f_ns_q;
      end
      if (inv_all)
        for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_q[f_idx_q][f_way_q] <= f_tag_q;
      dat_q[f_idx_q][f_way_q] <= mem_rdata;
    end
    if (accept && req_write)
      for (int w = 0; w < WAYS; w++)
        if (hit_vec[w]) dat_q[idx][w] <= req_wdata;
  end

  // R2
  rd_hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && hit) |=> (rsp_valid && rsp_hit && !mem_rd));
  // R3
  rd_miss_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && !hit) |=> (mem_rd && !rsp_valid && !req_ready));
  // R3
  refill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting_q && mem_rvalid) |=> (rsp_valid && !rsp_hit));
  // R8
  wr_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> (mem_wr && rsp_valid && !mem_rd));
  // R4
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: tb/tb_sec_tag_cache.sv
module tb_sec_tag_cache;
  localparam int AW = 16, DW = 32, SETS = 8, WAYS = 4, MEM_LAT = 3;

  logic clk = 0, rst_n = 0, inv_all = 0;
  logic req_valid = 0, req_write = 0, req_ns = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_hit, mem_rd, mem_wr, mem_ns;
  logic [DW-1:0] rsp_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic mem_rvalid = 0;
  logic [DW-1:0] mem_rdata = '0;

  always #5 clk = ~clk;

  sec_tag_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(SETS), .WAYS(WAYS)) dut (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_ns(req_ns), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_ns(mem_ns),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  logic [DW-1:0] wmem [int];
  int fetches = 0, lat_cnt = 0;
  logic [AW-1:0] last_rd_addr;
  logic last_rd_ns;
  int unsigned n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [DW-1:0] mval(input logic [AW-1:0] a, input logic ns);
    int key = {15'd0, ns, a};
    if (wmem.exists(key)) return wmem[key];
    return {ns ? 16'hC3C3 : 16'h3C3C, a};
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_wr) wmem[{15'd0, mem_ns, mem_addr}] = mem_wdata;
    if (mem_rd) begin
      fetches <= fetches + 1;
      last_rd_addr <= mem_addr;
      last_rd_ns <= mem_ns;
      lat_cnt <= MEM_LAT;
      mem_rdata <= mval(mem_addr, mem_ns);
    end else if (lat_cnt > 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) mem_rvalid <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic ns,
                    output logic [DW-1:0] d, output logic h, output int lat);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_ns = ns;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; lat = 1;
    while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
    d = rsp_rdata; h = rsp_hit;
  endtask

  task automatic invalidate();
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
  endtask

  task automatic t_reset();
    chk(req_ready === 1'b1, "R1 ready", req_ready, 1);
    chk(rsp_valid === 1'b0 && mem_rd === 1'b0 && mem_wr === 1'b0, "R1 idle outs",
        {rsp_valid, mem_rd, mem_wr}, 0);
  endtask

  task automatic t_miss_hit();
    logic [DW-1:0] d; logic h; int lat; int f0;
    f0 = fetches;
    rd(16'h0101, 0, d, h, lat);
    chk(h == 0, "R3 miss flag", h, 0);
    chk(lat > 1, "R3 miss latency", lat, 2);
    chk(d == mval(16'h0101, 0), "R3 miss data", d, mval(16'h0101, 0));
    chk(fetches == f0 + 1 && last_rd_addr == 16'h0101 && last_rd_ns == 0,
        "R3 fetch", last_rd_addr, 16'h0101);
    rd(16'h0101, 0, d, h, lat);
    chk(h == 1 && lat == 1, "R2 hit timing", {h, lat[7:0]}, 9'h101);
    chk(d == mval(16'h0101, 0), "R2 hit data", d, mval(16'h0101, 0));
    chk(fetches == f0 + 1, "R2 no fetch", fetches, f0 + 1);
  endtask

  task automatic t_worlds();
    logic [DW-1:0] d; logic h; int lat; int f0;
    f0 = fetches;
    rd(16'h0101, 1, d, h, lat);
    chk(h == 0 && last_rd_ns == 1 && fetches == f0 + 1, "R4 other world misses", h, 0);
    chk(d == mval(16'h0101, 1), "R4 world data", d, mval(16'h0101, 1));
    rd(16'h0101, 0, d, h, lat);
    chk(h == 1 && d == mval(16'h0101, 0), "R5 secure copy kept", d, mval(16'h0101, 0));
    rd(16'h0101, 1, d, h, lat);
    chk(h == 1 && d == mval(16'h0101, 1), "R5 nonsecure copy kept", d, mval(16'h0101, 1));
  endtask

  task automatic t_inv();
    logic [DW-1:0] d; logic h; int lat;
    invalidate();
    rd(16'h0101, 0, d, h, lat);
    chk(h == 0, "R1 invalidated secure", h, 0);
    rd(16'h0101, 1, d, h, lat);
    chk(h == 0, "R1 invalidated nonsecure", h, 0);
  endtask

  task automatic t_sets();
    logic [DW-1:0] d; logic h; int lat;
    invalidate();
    for (int i = 0; i < SETS; i++) rd(AW'(16'h0300 + i), 0, d, h, lat);
    for (int i = 0; i < SETS; i++) begin
      rd(AW'(16'h0300 + i), 0, d, h, lat);
      chk(h == 1, "R10 per-set line kept", i, 1);
    end
  endtask

  task automatic t_ways_evict(input logic [2:0] set, input logic own_ns);
    logic [DW-1:0] d; logic h; int lat; int misses;
    logic [AW-1:0] a;
    invalidate();
    for (int w = 0; w < WAYS; w++) rd({AW-3'(0) == 0 ? 13'(w + 1) : 13'(w + 1), set}, own_ns, d, h, lat);
    for (int w = 0; w < WAYS; w++) begin
      rd({13'(w + 1), set}, own_ns, d, h, lat);
      chk(h == 1, "R6 free way used", w, 1);
    end
    a = {13'h0100, set};
    rd(a, !own_ns, d, h, lat);
    chk(h == 0, "R7 intruder misses", h, 0);
    rd(a, !own_ns, d, h, lat);
    chk(h == 1 && d == mval(a, !own_ns), "R7 intruder resident", h, 1);
    misses = 0;
    for (int w = 0; w < WAYS; w++) begin
      rd({13'(w + 1), set}, own_ns, d, h, lat);
      if (!h) misses++;
    end
    chk(misses >= 1, "R7 other world evicted", misses, 1);
  endtask

  task automatic t_write();
    logic [DW-1:0] d; logic h; int lat;
    rd(16'h0404, 0, d, h, lat);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 16'h0404; req_ns = 0; req_wdata = 32'hDEADBEEF;
    @(posedge clk); @(negedge clk);
    req_valid = 0; req_write = 0;
    chk(rsp_valid && rsp_hit, "R8 write hit flag", {rsp_valid, rsp_hit}, 3);
    chk(mem_wr && mem_addr == 16'h0404 && mem_ns == 0 && mem_wdata == 32'hDEADBEEF,
        "R8 write through", mem_wdata, 32'hDEADBEEF);
    @(negedge clk);
    chk(!mem_wr, "R8 write pulse", mem_wr, 0);
    rd(16'h0404, 0, d, h, lat);
    chk(h == 1 && d == 32'hDEADBEEF, "R9 write hit updates", d, 32'hDEADBEEF);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 16'h0504; req_ns = 1; req_wdata = 32'h12345678;
    @(posedge clk); @(negedge clk);
    req_valid = 0; req_write = 0;
    chk(rsp_valid && !rsp_hit && mem_wr && mem_ns, "R8 write miss", {rsp_valid, rsp_hit, mem_wr}, 5);
    rd(16'h0504, 1, d, h, lat);
    chk(h == 0 && d == 32'h12345678, "R9 no allocate on write", {h, d}, 33'h012345678);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_miss_hit();
    t_worlds();
    t_inv();
    t_sets();
    t_ways_evict(3'd5, 1'b0);
    t_ways_evict(3'd6, 1'b1);
    t_write();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule